// File: doc/BRIEF.md
# Bit-Slip and Pattern Word Aligner

This block restores the word boundary of a receive stream that reaches it as parallel words of raw line bits, `W` bits per clock (10 or 20 in practice). Bit 0 of each input word is the earliest bit on the line. The block registers the incoming word, keeps the word before it, and returns a `W`-bit window cut from the pair at a bit offset held in the block.

The offset is moved in one of two ways, chosen at run time by `mode_i`. In slip mode (`mode_i` = 0), each rising edge of the slip request moves the boundary one bit toward later bits. The earliest bit is dropped, and the offset wraps from `W-1` back to 0. In search mode (`mode_i` = 1), a rising edge of the align request arms a search. On every cycle, the block tests each candidate offset at once against a fixed alignment pattern of `PAT_LEN` bits (7 to 32, no wider than `W`). When the pattern is seen, the offset jumps to where it was found, a one-cycle found pulse is raised, and the search disarms until the next request edge.

Both request inputs may be asynchronous to `clk`. Each one crosses a two-stage synchronizer followed by a rising-edge detector, so a request held high acts only once.

Top module: `wa_aligner`

## Requirements
- R1: `data_o` equals bits `[off + W - 1 : off]` of the concatenation {current registered word, previous registered word}, where `off` = `offset_o`. The previous word occupies bits `[W-1:0]`. A word on `data_i` becomes the current word at the next rising clock edge.
- R2: After reset, `offset_o` is 0, `found_o` is 0 and no search is armed.
- R3: In slip mode (`mode_i` = 0), a rising edge on `slip_req_i` increments `offset_o` by exactly one. The change appears after the third rising clock edge that samples the request high, and not before.
- R4: A request input held high for many cycles causes only one action (one slip, or one arming).
- R5: Slipping from offset `W-1` gives offset 0.
- R6: A slip request in search mode leaves `offset_o` unchanged. An align request edge seen in slip mode does not arm a search.
- R7: When a search is armed in search mode and, for some candidate `k` in 0..`W-1`, bits `[k + PAT_LEN - 1 : k]` of the concatenation equal the low `PAT_LEN` bits of `PATTERN`: at the next edge `offset_o` becomes `k` and `found_o` is high for exactly that one cycle.
- R8: After a find, the search is disarmed. Later pattern occurrences change neither `offset_o` nor `found_o` until a new align request edge arrives.
- R9: When several candidate offsets match in the same cycle, the lowest one is taken.
- R10: `offset_o` is always below `W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = slip mode, 1 = pattern search mode |
| slip_req_i | input | 1 | Slip request; its rising edge moves the boundary by one bit |
| align_req_i | input | 1 | Align request; its rising edge arms a pattern search |
| data_i | input | W | Raw received bits, bit 0 earliest |
| data_o | output | W | Aligned word |
| offset_o | output | $clog2(W) | Current boundary offset in bits |
| found_o | output | 1 | One-cycle pulse when an armed search locks |

## Verification
The bench builds the block with `W` = 10 and a 7-bit pattern `0011111`. This keeps the whole offset space small enough to sweep fully. It walks every offset through eleven slips, which covers the wrap. At each offset it compares the window against random words. For each of the ten offsets, it places the pattern so that its position is unique and checks that the search locks there. Two widely spaced copies of the pattern fit inside the 20-bit pair, which makes the lowest-offset priority observable. The narrow pattern also lets a second, unrequested occurrence test the disarm.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic {
    WA_SLIP   = 1'b0,
    WA_SEARCH = 1'b1
  } wa_mode_e;
endpackage

// File: rtl/wa_edge_sync.sv
module wa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], req_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wa_window_mux.sv
module wa_window_mux #(
  parameter int W    = 10,
  parameter int OFFW = $clog2(W)
) (
  input  logic [2*W-1:0]  pair_i,
  input  logic [OFFW-1:0] off_i,
  output logic [W-1:0]    win_o
);
  function automatic logic [W-1:0] cut(input logic [2*W-1:0] p, input logic [OFFW-1:0] k);
    logic [W-1:0] r;
    r = '0;
    for (int b = 0; b < W; b++) r[b] = p[int'(k) + b];
    return r;
  endfunction

  assign win_o = cut(pair_i, off_i);
endmodule

// File: rtl/wa_pattern_scan.sv
module wa_pattern_scan #(
  parameter int          W       = 10,
  parameter int          PAT_LEN = 7,
  parameter logic [31:0] PATTERN = 32'h0000_001F,
  parameter int          OFFW    = $clog2(W)
) (
  input  logic [2*W-1:0]  pair_i,
  output logic            hit_o,
  output logic [OFFW-1:0] idx_o
);
  localparam logic [PAT_LEN-1:0] PAT = PATTERN[PAT_LEN-1:0];

  logic [W-1:0] hit_vec;

  for (genvar k = 0; k < W; k++) begin : g_cand
    assign hit_vec[k] = (pair_i[k +: PAT_LEN] == PAT);
  end

  always_comb begin
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_vec[k]) idx_o = OFFW'(k);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/wa_aligner.sv
module wa_aligner
  import wa_pkg::*;
#(
  parameter int          W       = 10,
  parameter int          PAT_LEN = 7,
  parameter logic [31:0] PATTERN = 32'h0000_001F,
  parameter int          OFFW    = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic            slip_req_i,
  input  logic            align_req_i,
  input  logic [W-1:0]    data_i,
  output logic [W-1:0]    data_o,
  output logic [OFFW-1:0] offset_o,
  output logic            found_o
);
  localparam logic [OFFW-1:0] OFF_LAST = OFFW'(W - 1);

  function automatic logic [OFFW-1:0] step_off(input logic [OFFW-1:0] k);
    return (k == OFF_LAST) ? '0 : k + 1'b1;
  endfunction

  wa_mode_e        mode;
  logic [W-1:0]    cur_q, prev_q;
  logic [2*W-1:0]  pair;
  logic            slip_evt, align_evt;
  logic            slip_fire, arm_fire, find_fire;
  logic            hit_any;
  logic [OFFW-1:0] hit_idx;
  logic            armed_q, found_q;
  logic [OFFW-1:0] off_q;

  assign mode = wa_mode_e'(mode_i);
  assign pair = {cur_q, prev_q};

  wa_edge_sync #(.STAGES(2)) u_slip_sync (
    .clk(clk), .rst_n(rst_n), .req_i(slip_req_i), .rise_o(slip_evt)
  );

  wa_edge_sync #(.STAGES(2)) u_align_sync (
    .clk(clk), .rst_n(rst_n), .req_i(align_req_i), .rise_o(align_evt)
  );

  wa_pattern_scan #(.W(W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .OFFW(OFFW)) u_scan (
    .pair_i(pair), .hit_o(hit_any), .idx_o(hit_idx)
  );

  wa_window_mux #(.W(W), .OFFW(OFFW)) u_mux (
    .pair_i(pair), .off_i(off_q), .win_o(data_o)
  );

  assign slip_fire = slip_evt  && (mode == WA_SLIP);
  assign arm_fire  = align_evt && (mode == WA_SEARCH);
  assign find_fire = armed_q && hit_any && (mode == WA_SEARCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      prev_q  <= '0;
      off_q   <= '0;
      armed_q <= 1'b0;
      found_q <= 1'b0;
    end else begin
      cur_q   <= data_i;
      prev_q  <= cur_q;
      found_q <= find_fire;
      if (mode == WA_SLIP)  armed_q <= 1'b0;
      else if (find_fire)   armed_q <= 1'b0;
      else if (arm_fire)    armed_q <= 1'b1;
      if (slip_fire)        off_q <= step_off(off_q);
      else if (find_fire)   off_q <= hit_idx;
    end
  end

  assign offset_o = off_q;
  assign found_o  = found_q;
endmodule

// File: rtl/wa_aligner_chk.sv
module wa_aligner_chk #(
  parameter int W    = 10,
  parameter int OFFW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_i,
  input logic [OFFW-1:0] offset_o,
  input logic            found_o,
  input logic            slip_fire,
  input logic            hit_any,
  input logic [OFFW-1:0] hit_idx,
  input logic            armed_q
);
  function automatic logic [OFFW-1:0] nxt(input logic [OFFW-1:0] k);
    return (int'(k) == W - 1) ? '0 : k + 1'b1;
  endfunction

  a_r3_slip_step: assert property (@(posedge clk) disable iff (!rst_n)
    slip_fire |=> (offset_o == nxt($past(offset_o))));

  a_r3_offset_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_o != $past(offset_o)) |-> ($past(slip_fire) || found_o));

  a_r7_found_offset: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (offset_o == $past(hit_idx)));

  a_r7_found_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> $past(hit_any && armed_q));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |=> !found_o);

  a_r6_no_arm_in_slip: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> !armed_q);

  a_r10_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(offset_o) < W);
endmodule

bind wa_aligner wa_aligner_chk #(.W(W), .OFFW(OFFW)) u_chk (.*);

// File: tb/sim_wa_aligner.sv
module sim_wa_aligner;
  localparam int W    = 10;
  localparam int PL   = 7;
  localparam int OFFW = $clog2(W);
  localparam logic [31:0] PAT = 32'h0000_001F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, slip = 1'b0, align = 1'b0;
  logic [W-1:0] din = '0, dout;
  logic [OFFW-1:0] off;
  logic found;

  int n_run = 0, n_fail = 0, exp_off = 0;
  logic [W-1:0] m_cur = '0, m_prev = '0;
  bit done = 0;

  always #5 clk = ~clk;

  wa_aligner #(.W(W), .PAT_LEN(PL), .PATTERN(PAT)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .slip_req_i(slip), .align_req_i(align),
    .data_i(din), .data_o(dout), .offset_o(off), .found_o(found)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_win(input int k);
    logic [2*W-1:0] p = {m_cur, m_prev};
    return W'(p >> k);
  endfunction

  task automatic feed(input logic [W-1:0] w);
    @(negedge clk);
    din = w; m_prev = m_cur; m_cur = w;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_align();
    @(negedge clk); align = 1'b1;
    repeat (6) tick();
    @(negedge clk); align = 1'b0;
    repeat (4) tick();
  endtask

  task automatic feed_pair(input logic [2*W-1:0] v);
    feed(v[W-1:0]); feed(v[2*W-1:W]);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) feed('0);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R2 offset", off, 0);
    chk("R2 found", found, 0);

    // R3 R4 R5 R1: full slip walk with wrap
    for (int s = 0; s <= W; s++) begin
      for (int r = 0; r < 3; r++) begin
        feed(W'($urandom));
        tick();
        chk("R1 window", dout, model_win(exp_off));
      end
      @(negedge clk); slip = 1'b1;
      tick(); tick();
      chk("R3 no early slip", off, exp_off);
      tick();
      exp_off = (exp_off + 1) % W;
      chk("R3/R5 slip step", off, exp_off);
      repeat (5) tick();
      chk("R4 held level once", off, exp_off);
      @(negedge clk); slip = 1'b0;
      repeat (4) tick();
      chk("R10 offset range", (int'(off) < W), 1);
    end

    // R6: slip ignored in search mode
    @(negedge clk); mode = 1'b1;
    @(negedge clk); slip = 1'b1;
    repeat (6) tick();
    @(negedge clk); slip = 1'b0;
    repeat (4) tick();
    chk("R6 slip ignored", off, exp_off);

    // R6: align edge ignored in slip mode
    @(negedge clk); mode = 1'b0;
    pulse_align();
    @(negedge clk); mode = 1'b1;
    feed_pair((2*W)'(PAT[PL-1:0]) << 4);
    feed('0); tick();
    chk("R6 no arm found", found, 0);
    chk("R6 no arm offset", off, exp_off);
    flush();

    // R7 sweep over every candidate offset
    for (int k = 0; k < W; k++) begin
      pulse_align();
      feed_pair((2*W)'(PAT[PL-1:0]) << k);
      tick(); tick();
      chk("R7 found pulse", found, 1);
      chk("R7 offset lock", off, k);
      tick();
      chk("R7 pulse one cycle", found, 0);
      flush();
      exp_off = k;
    end

    // R8: disarmed after find
    feed_pair((2*W)'(PAT[PL-1:0]) << 2);
    tick(); tick();
    chk("R8 no refind", found, 0);
    chk("R8 offset kept", off, exp_off);
    flush();

    // R9: two matches, lowest wins
    pulse_align();
    feed_pair(((2*W)'(PAT[PL-1:0]) << 1) | ((2*W)'(PAT[PL-1:0]) << 8));
    tick(); tick();
    chk("R9 found", found, 1);
    chk("R9 lowest offset", off, 1);
    flush();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule